// File: doc/BRIEF.md
# Powered-Port Fault Supervisor

This block watches a group of powered Ethernet ports (four by default) and removes power from any port that misbehaves. For each port it takes a digitized current code and a digitized voltage code every clock cycle, together with the port's enable request and a flag that says the output ramp has finished. A chip-wide over-temperature flag is also an input. Each port has five timed fault conditions: overcurrent, hard current limit, DC disconnect (current too low), under-voltage and over-voltage. A timer for a condition counts ticks of a divided internal clock while the condition holds. When a timer expires, the port is switched off and a sticky status bit is recorded.

Status bits stay set until software clears them with a write-one-to-clear pulse. A port with any status bit set stays unpowered even if its enable is still asserted. An active-low interrupt output is the OR of every status bit of every port. Disconnect detection and voltage-fault checking each have a per-port disable input. The measurement codes come in as plain sampled buses with no handshake. A new code is assumed every cycle, so there is no back-pressure path.

Top module: `poe_fault_supervisor`

## Requirements
- R1: With no status bit set and the thermal flag low, a port's power output goes high one clock after its enable goes high, and goes low one clock after the enable goes low.
- R2: When a powered port's current code stays above the overcurrent code for OC_TICKS consecutive ticks, the port turns off and status bit 0 of that port is set.
- R3: When a powered port's current code stays above the hard-limit code for LIM_TICKS consecutive ticks, the port turns off and status bit 1 is set. With LIM_TICKS below OC_TICKS, only bit 1 is recorded.
- R4: Each fault timer returns to zero whenever its condition is absent on a tick, so an excursion shorter than the window never trips, even if it repeats.
- R5: When a powered port's current code stays below the disconnect code for DISC_TICKS ticks, the port turns off and status bit 2 is set. While that port's disconnect-disable input is high, low current has no effect.
- R6: A voltage code below the under-voltage code (status bit 3) or above the over-voltage code (status bit 4) turns the port off after VF_TICKS ticks. This applies only while the port's ramp-done input is high and its voltage-disable input is low.
- R7: When the thermal flag is high at a clock edge, every port is off after that edge and status bit 5 is set in every port.
- R8: Status bits are sticky. A bit clears only when its own clear input is pulsed, and clear pulses on other bits leave it set. Port p uses status and clear bits 6p to 6p+5.
- R9: The interrupt output is low while any status bit of any port is set, and high once all are clear.
- R10: A port with any status bit set stays off while its enable is high, and may power again only after all its bits are cleared.
- R11: After reset all ports are off, all status bits are zero and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en_i | input | NPORTS | Power request per port |
| ramp_done_i | input | NPORTS | Port output has finished ramping |
| i_code_i | input | NPORTS*CODE_W | Current code per port, port p at bits p*CODE_W upward |
| v_code_i | input | NPORTS*CODE_W | Voltage code per port |
| therm_i | input | 1 | Die over-temperature flag |
| disc_dis_i | input | NPORTS | Disable disconnect detection per port |
| vf_dis_i | input | NPORTS | Disable voltage-fault checking per port |
| clr_i | input | NPORTS*6 | Write-one-to-clear pulses for status bits |
| port_on_o | output | NPORTS | Port power switch control |
| status_o | output | NPORTS*6 | Sticky fault status, per port {therm, ov, uv, disc, lim, oc} |
| int_n_o | output | 1 | Active-low shared interrupt |

## Verification
The bench drives current codes that sit between the overcurrent and hard-limit codes, and separately codes above the hard limit. This shows which of the two timers is responsible for a trip. Low-current and out-of-range voltage codes are applied with the matching disable or ramp-done gate set both ways, to separate a real trip from a check that should be masked. Bursts of fault codes one tick shorter than the window, some repeated back to back, show whether each timer really restarts. Random in-band codes, screened by a bench function, show that ordinary load variation never produces a trip.

// File: rtl/poe_sup_pkg.sv
package poe_sup_pkg;
  localparam int NFLT     = 6;
  localparam int NTIMED   = 5;
  localparam int FB_OC    = 0;
  localparam int FB_LIM   = 1;
  localparam int FB_DISC  = 2;
  localparam int FB_UV    = 3;
  localparam int FB_OV    = 4;
  localparam int FB_THERM = 5;
  typedef logic [NFLT-1:0] flt_vec_t;
endpackage

// File: rtl/psup_tick.sv
module psup_tick #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/psup_timer.sv
module psup_timer #(
  parameter int LIMIT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cond_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Count ticks while the condition holds; any cycle without it restarts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!cond_i)   cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = cond_i & tick_i & (cnt_q == LAST);
endmodule

// File: rtl/psup_port.sv
module psup_port
  import poe_sup_pkg::*;
#(
  parameter int CODE_W     = 15,
  parameter int OC_TICKS   = 75,
  parameter int LIM_TICKS  = 75,
  parameter int DISC_TICKS = 350,
  parameter int VF_TICKS   = 60,
  parameter int ICUT_CODE  = 22400,
  parameter int ILIM_CODE  = 23660,
  parameter int IDISC_CODE = 273,
  parameter int VUV_CODE   = 15073,
  parameter int VOV_CODE   = 19415
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              ramp_i,
  input  logic [CODE_W-1:0] i_code_i,
  input  logic [CODE_W-1:0] v_code_i,
  input  logic              therm_i,
  input  logic              disc_dis_i,
  input  logic              vf_dis_i,
  input  flt_vec_t          clr_i,
  output logic              on_o,
  output flt_vec_t          status_o
);
  localparam logic [CODE_W-1:0] ICUT  = CODE_W'(ICUT_CODE);
  localparam logic [CODE_W-1:0] ILIM  = CODE_W'(ILIM_CODE);
  localparam logic [CODE_W-1:0] IDISC = CODE_W'(IDISC_CODE);
  localparam logic [CODE_W-1:0] VUV   = CODE_W'(VUV_CODE);
  localparam logic [CODE_W-1:0] VOV   = CODE_W'(VOV_CODE);

  logic              on_q;
  flt_vec_t          status_q;
  logic [NTIMED-1:0] cond;
  logic [NTIMED-1:0] trip;
  logic              vcheck;

  // Voltage window is only meaningful once the output has ramped.
  assign vcheck = on_q & ramp_i & ~vf_dis_i;

  always_comb begin
    cond          = '0;
    cond[FB_OC]   = on_q & (i_code_i > ICUT);
    cond[FB_LIM]  = on_q & (i_code_i > ILIM);
    cond[FB_DISC] = on_q & ~disc_dis_i & (i_code_i < IDISC);
    cond[FB_UV]   = vcheck & (v_code_i < VUV);
    cond[FB_OV]   = vcheck & (v_code_i > VOV);
  end

  for (genvar k = 0; k < NTIMED; k++) begin : g_tmr
    localparam int WIN = (k == FB_OC)   ? OC_TICKS  :
                         (k == FB_LIM)  ? LIM_TICKS :
                         (k == FB_DISC) ? DISC_TICKS : VF_TICKS;
    psup_timer #(.LIMIT(WIN)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .cond_i   (cond[k]),
      .expire_o (trip[k])
    );
  end

  flt_vec_t set_v;
  assign set_v = {therm_i, trip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      on_q     <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_v;
      on_q     <= en_i & ~therm_i & ~(|trip) & ~(|status_q);
    end
  end

  assign on_o     = on_q;
  assign status_o = status_q;
endmodule

// File: rtl/poe_fault_supervisor.sv
module poe_fault_supervisor
  import poe_sup_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int CODE_W     = 15,
  parameter int TICK_DIV   = 1000,
  parameter int OC_TICKS   = 75,
  parameter int LIM_TICKS  = 75,
  parameter int DISC_TICKS = 350,
  parameter int VF_TICKS   = 60,
  parameter int ICUT_CODE  = 22400,
  parameter int ILIM_CODE  = 23660,
  parameter int IDISC_CODE = 273,
  parameter int VUV_CODE   = 15073,
  parameter int VOV_CODE   = 19415
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        port_en_i,
  input  logic [NPORTS-1:0]        ramp_done_i,
  input  logic [NPORTS*CODE_W-1:0] i_code_i,
  input  logic [NPORTS*CODE_W-1:0] v_code_i,
  input  logic                     therm_i,
  input  logic [NPORTS-1:0]        disc_dis_i,
  input  logic [NPORTS-1:0]        vf_dis_i,
  input  logic [NPORTS*6-1:0]      clr_i,
  output logic [NPORTS-1:0]        port_on_o,
  output logic [NPORTS*6-1:0]      status_o,
  output logic                     int_n_o
);
  logic tick;

  psup_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    psup_port #(
      .CODE_W(CODE_W), .OC_TICKS(OC_TICKS), .LIM_TICKS(LIM_TICKS),
      .DISC_TICKS(DISC_TICKS), .VF_TICKS(VF_TICKS),
      .ICUT_CODE(ICUT_CODE), .ILIM_CODE(ILIM_CODE), .IDISC_CODE(IDISC_CODE),
      .VUV_CODE(VUV_CODE), .VOV_CODE(VOV_CODE)
    ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .en_i       (port_en_i[p]),
      .ramp_i     (ramp_done_i[p]),
      .i_code_i   (i_code_i[p*CODE_W +: CODE_W]),
      .v_code_i   (v_code_i[p*CODE_W +: CODE_W]),
      .therm_i    (therm_i),
      .disc_dis_i (disc_dis_i[p]),
      .vf_dis_i   (vf_dis_i[p]),
      .clr_i      (clr_i[p*NFLT +: NFLT]),
      .on_o       (port_on_o[p]),
      .status_o   (status_o[p*NFLT +: NFLT])
    );
  end

  assign int_n_o = ~(|status_o);
endmodule

// File: rtl/psup_checker.sv
module psup_checker #(
  parameter int NPORTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORTS-1:0]   port_en_i,
  input logic                therm_i,
  input logic [NPORTS*6-1:0] clr_i,
  input logic [NPORTS-1:0]   port_on_o,
  input logic [NPORTS*6-1:0] status_o,
  input logic                int_n_o
);
  // R7
  therm_kills_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_i |=> (port_on_o == '0));

  // R9
  int_low_on_new_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|status_o) |-> !int_n_o);

  for (genvar p = 0; p < NPORTS; p++) begin : g_pc
    // R10
    faulted_port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|status_o[p*6 +: 6]) |-> !port_on_o[p]);
    // R1
    drop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en_i[p] |=> !port_on_o[p]);
    // R1
    power_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_on_o[p]) |-> $past(port_en_i[p]));
  end

  for (genvar b = 0; b < NPORTS*6; b++) begin : g_bc
    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[b] && !clr_i[b]) |=> status_o[b]);
  end
endmodule

bind poe_fault_supervisor psup_checker #(.NPORTS(NPORTS)) u_psup_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_en_i (port_en_i),
  .therm_i   (therm_i),
  .clr_i     (clr_i),
  .port_on_o (port_on_o),
  .status_o  (status_o),
  .int_n_o   (int_n_o)
);

// File: tb/poe_fault_supervisor_test.sv
module poe_fault_supervisor_test;
  localparam int NP = 4, CW = 15, TD = 2;
  localparam int OC = 7, LIM = 4, DISC = 10, VF = 5;
  localparam int ICUT = 22400, ILIM = 23660, IDISC = 273, VUV = 15073, VOV = 19415;
  localparam int NORM_I = 10000, NORM_V = 17000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] en = '0, ramp = '0, ddis = '0, vdis = '0;
  logic [NP*CW-1:0] icode = '0, vcode = '0;
  logic therm = 1'b0;
  logic [NP*6-1:0] clr = '0;
  logic [NP-1:0] on;
  logic [NP*6-1:0] st;
  logic int_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  poe_fault_supervisor #(
    .NPORTS(NP), .CODE_W(CW), .TICK_DIV(TD), .OC_TICKS(OC), .LIM_TICKS(LIM),
    .DISC_TICKS(DISC), .VF_TICKS(VF), .ICUT_CODE(ICUT), .ILIM_CODE(ILIM),
    .IDISC_CODE(IDISC), .VUV_CODE(VUV), .VOV_CODE(VOV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .port_en_i(en), .ramp_done_i(ramp),
    .i_code_i(icode), .v_code_i(vcode), .therm_i(therm), .disc_dis_i(ddis),
    .vf_dis_i(vdis), .clr_i(clr), .port_on_o(on), .status_o(st), .int_n_o(int_n)
  );

  // Expected fault conditions of one code pair, from the requirements
  function automatic logic [4:0] exp_cond(input int i, input int v);
    exp_cond = {v > VOV, v < VUV, i < IDISC, i > ILIM, i > ICUT};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_i(input int p, input int val);
    icode[p*CW +: CW] = CW'(val);
  endtask

  task automatic set_v(input int p, input int val);
    vcode[p*CW +: CW] = CW'(val);
  endtask

  task automatic clear_all();
    clr = '1; cyc(1); clr = '0; cyc(2);
  endtask

  function automatic int pst(input int p);
    pst = int'(st[p*6 +: 6]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) begin set_i(p, NORM_I); set_v(p, NORM_V); end
    cyc(3);
    // R11 reset state
    check(on == '0, "R11 ports off", int'(on), 0);
    check(st == '0, "R11 status clear", int'(st != '0), 0);
    check(int_n == 1'b1, "R11 interrupt high", int'(int_n), 1);
    rst_n = 1'b1; cyc(2);

    // R1 power up
    en = '1; ramp = '1; cyc(2);
    check(on == 4'hF, "R1 power on", int'(on), 15);
    en[3] = 1'b0; cyc(2);
    check(on == 4'h7, "R1 power off on disable", int'(on), 7);
    en[3] = 1'b1; cyc(2);

    // R2 overcurrent, between cutoff and hard limit
    set_i(0, 22800); cyc((OC-1)*TD-1);
    check(on[0] == 1'b1, "R2 before window", int'(on[0]), 1);
    cyc(5);
    check(on[0] == 1'b0, "R2 port off", int'(on[0]), 0);
    check(pst(0) == 1, "R2 status bit0", pst(0), 1);
    check(int_n == 1'b0, "R9 interrupt low", int'(int_n), 0);
    set_i(0, NORM_I); cyc(4);
    check(on[0] == 1'b0, "R10 stays off while flagged", int'(on[0]), 0);
    clear_all();
    check(int_n == 1'b1, "R9 interrupt high after clear", int'(int_n), 1);
    check(on[0] == 1'b1, "R10 repowers after clear", int'(on[0]), 1);

    // R3 hard limit trips first
    set_i(1, 24000); cyc((LIM-1)*TD-1);
    check(on[1] == 1'b1, "R3 before window", int'(on[1]), 1);
    cyc(5);
    check(on[1] == 1'b0, "R3 port off", int'(on[1]), 0);
    check(pst(1) == 2, "R3 status only bit1", pst(1), 2);
    set_i(1, NORM_I); clear_all();

    // R4 timer restarts on a gap
    for (int r = 0; r < 3; r++) begin
      set_i(2, 22800); cyc((OC-1)*TD-1);
      set_i(2, NORM_I); cyc(TD+1);
    end
    check(on[2] == 1'b1 && pst(2) == 0, "R4 repeated short bursts", pst(2), 0);

    // R5 disconnect and its disable
    set_i(3, 100); cyc((DISC-1)*TD-1);
    check(on[3] == 1'b1, "R5 before window", int'(on[3]), 1);
    cyc(5);
    check(pst(3) == 4 && !on[3], "R5 disconnect bit2", pst(3), 4);
    set_i(3, NORM_I); clear_all();
    ddis[3] = 1'b1; set_i(3, 100); cyc(4*DISC*TD);
    check(on[3] == 1'b1 && pst(3) == 0, "R5 disabled no effect", pst(3), 0);
    set_i(3, NORM_I); ddis[3] = 1'b0; cyc(2);

    // R6 under-voltage gated by ramp, over-voltage, voltage disable
    ramp[0] = 1'b0; set_v(0, 10000); cyc(6*VF*TD);
    check(on[0] == 1'b1 && pst(0) == 0, "R6 ignored before ramp", pst(0), 0);
    ramp[0] = 1'b1; cyc((VF-1)*TD-1);
    check(on[0] == 1'b1, "R6 before window", int'(on[0]), 1);
    cyc(5);
    check(pst(0) == 8 && !on[0], "R6 under-voltage bit3", pst(0), 8);
    set_v(0, NORM_V); clear_all();
    set_v(1, 20000); cyc(VF*TD+3);
    check(pst(1) == 16 && !on[1], "R6 over-voltage bit4", pst(1), 16);
    set_v(1, NORM_V); clear_all();
    vdis[2] = 1'b1; set_v(2, 10000); cyc(6*VF*TD);
    check(on[2] == 1'b1 && pst(2) == 0, "R6 disabled no effect", pst(2), 0);
    set_v(2, NORM_V); vdis[2] = 1'b0; cyc(2);

    // R7 thermal shutdown, R8 selective clear
    therm = 1'b1; cyc(1); therm = 1'b0; cyc(1);
    check(on == '0, "R7 all ports off", int'(on), 0);
    for (int p = 0; p < NP; p++) check(pst(p) == 32, "R7 thermal bit5", pst(p), 32);
    clr = {NP{6'b000001}}; cyc(1); clr = '0; cyc(2);
    check(st == {NP{6'b100000}}, "R8 other clear keeps bit", pst(0), 32);
    check(on == '0, "R10 off after therm drops", int'(on), 0);
    clr = {NP{6'b100000}}; cyc(1); clr = '0; cyc(2);
    check(st == '0 && on == 4'hF, "R8 own clear releases", int'(on), 15);

    // Random in-band load and short overcurrent bursts: no trip expected
    for (int it = 0; it < 40; it++) begin
      int p = int'($urandom_range(NP-1, 0));
      int iv, vv;
      do begin
        iv = int'($urandom_range(22000, 300));
        vv = int'($urandom_range(19400, 15100));
      end while (exp_cond(iv, vv) != 5'd0);
      set_i(p, iv); set_v(p, vv); cyc(int'($urandom_range(10, 1)));
      if ($urandom_range(1, 0) == 1) begin
        set_i(p, 22800); cyc(int'($urandom_range((OC-1)*TD-1, 1)));
        set_i(p, iv); cyc(TD+1);
      end
    end
    check(st == '0 && on == 4'hF, "R4 random in-band never trips", int'(st != '0), 0);
    check(int_n == 1'b1, "R9 quiet after random", int'(int_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule